// File: doc/BRIEF.md
# Host Buffer Transfer Byte Counter

This block keeps track of how many bytes have moved between a host processor and one of two on-chip buffer memories: an isochronous buffer and an acknowledged-transfer buffer. The transfer can be programmed I/O or DMA. Software programs a 16-bit byte count and a 3-bit DMA setup register through a command/data port. It first writes a command byte, then reads or writes one data word.

Buffer traffic reaches the block as word and byte strobes. A word strobe moves two bytes and a byte strobe moves one. When the running total reaches the programmed count, the block does three things:
- it fires an end-of-transfer event;
- it latches an interrupt flag;
- it pulses a buffer-status update.

With the DMA counter enabled, the DMA request follows the count. With the counter disabled, only an external end-of-transfer input stops the DMA request.

Top module: `xfer_byte_counter`

## Requirements
- R1: After reset, the byte count, the setup register and the interrupt flag all read 0. `dma_req`, `buf_status_upd` and `limit_err` are low.
- R2: The byte count is written with command 0xA2 followed by a data write. It is read back with command 0x22 followed by a data read.
- R3: A count above the limit of the selected buffer is stored as that limit and sets the sticky `limit_err`. The limit is 0x1000 when setup bit 1 is 1 and 0x0800 when it is 0. A count equal to the limit is stored unchanged.
- R4: While a transfer is armed and active, a word strobe adds 2 bytes and a byte strobe adds 1. When the total reaches or passes the count, the interrupt flag (bit 2 of the status word) is set after that clock edge.
- R5: `buf_status_upd` is high for exactly one cycle, in the cycle after the edge that ends the transfer.
- R6: Status is read with command 0x24, with the flag in bit 2. Writing command 0xA4 with data bit 2 = 1 clears the flag. Writing 0 in bit 2 leaves it set.
- R7: With setup bit 2 = 1, `dma_req` is high only while `dma_enable` is high and a non-zero count is armed. It drops in the same cycle as the status pulse and stays low until the count is rewritten or `dma_enable` rises again.
- R8: With setup bit 2 = 0, `dma_req` follows `dma_enable`, and strobes do not advance the total. An `ext_eot` pulse drops `dma_req` and sets the flag. `dma_req` stays low until `dma_enable` rises again.
- R9: Writing the count restarts the running total from zero.
- R10: The setup register is written with command 0xA1 and read with command 0x21 in bits [2:0]. Bit 2 enables the counter, bit 1 selects the buffer and bit 0 gives the direction. Bits 1 and 0 also appear on `buf_sel_atl` and `buf_dir_wr`.
- R11: Strobes are ignored when `pio_active` is low and the DMA counter is not running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wr | input | 1 | Command byte strobe |
| cmd_in | input | 8 | Command byte |
| data_wr | input | 1 | Data word write strobe |
| data_in | input | 16 | Data word in |
| data_out | output | 16 | Register selected by the last read command |
| pio_active | input | 1 | Programmed-I/O transfer in progress |
| dma_enable | input | 1 | DMA enabled |
| word_stb | input | 1 | Two bytes moved |
| byte_stb | input | 1 | One byte moved |
| ext_eot | input | 1 | External end-of-transfer |
| dma_req | output | 1 | DMA request |
| irq_eot | output | 1 | End-of-transfer interrupt flag |
| buf_status_upd | output | 1 | Buffer-status update pulse |
| limit_err | output | 1 | Sticky over-limit flag |
| buf_sel_atl | output | 1 | 1 selects the acknowledged-transfer buffer |
| buf_dir_wr | output | 1 | 1 means write to the buffer |

## Verification
A wrong running total shows up as an interrupt flag and status pulse that arrive one strobe early or late. This is visible in the very cycle after the strobe that should have ended the transfer. A wrong arm state shows up at once on `dma_req`, either while the count is zero or after completion. A clamp fault shows up in the very next read of the count.

// File: rtl/xbc_pkg.sv
package xbc_pkg;
   localparam logic [7:0] CMD_CNT_RD = 8'h22;
   localparam logic [7:0] CMD_CNT_WR = 8'hA2;
   localparam logic [7:0] CMD_CFG_RD = 8'h21;
   localparam logic [7:0] CMD_CFG_WR = 8'hA1;
   localparam logic [7:0] CMD_IRQ_RD = 8'h24;
   localparam logic [7:0] CMD_IRQ_WR = 8'hA4;
   localparam int         IRQ_BIT    = 2;

   typedef struct packed {
      logic cnt_en;
      logic sel_atl;
      logic dir_wr;
   } cfg_t;
endpackage

// File: rtl/xbc_regs.sv
module xbc_regs
   import xbc_pkg::*;
#(
   parameter int W         = 16,
   parameter int ATL_LIMIT = 'h1000,
   parameter int ITL_LIMIT = 'h0800
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cmd_wr,
   input  logic [7:0]   cmd_in,
   input  logic         data_wr,
   input  logic [W-1:0] data_in,
   input  logic         irq_q,
   output cfg_t         cfg_q,
   output logic [W-1:0] count_q,
   output logic [W-1:0] cnt_next,
   output logic         cnt_load,
   output logic         irq_clr,
   output logic         limit_err,
   output logic [W-1:0] data_out
);
   localparam logic [W-1:0] ATL_L = ATL_LIMIT[W-1:0];
   localparam logic [W-1:0] ITL_L = ITL_LIMIT[W-1:0];

   logic [7:0]   cmd_q;
   logic [W-1:0] limit;
   logic         over;

   assign limit    = cfg_q.sel_atl ? ATL_L : ITL_L;
   assign over     = data_in > limit;
   assign cnt_next = over ? limit : data_in;
   assign cnt_load = data_wr && (cmd_q == CMD_CNT_WR);
   assign irq_clr  = data_wr && (cmd_q == CMD_IRQ_WR) && data_in[IRQ_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q     <= '0;
         cfg_q     <= '0;
         count_q   <= '0;
         limit_err <= 1'b0;
      end else begin
         if (cmd_wr) cmd_q <= cmd_in;
         if (data_wr && cmd_q == CMD_CFG_WR) cfg_q <= cfg_t'(data_in[2:0]);
         if (cnt_load) begin
            count_q <= cnt_next;
            if (over) limit_err <= 1'b1;
         end
      end
   end

   always_comb begin
      data_out = '0;
      case (cmd_q)
         CMD_CNT_RD: data_out = count_q;
         CMD_CFG_RD: data_out[2:0] = cfg_q;
         CMD_IRQ_RD: data_out[IRQ_BIT] = irq_q;
         default:    data_out = '0;
      endcase
   end
endmodule

// File: rtl/xbc_progress.sv
module xbc_progress #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cnt_load,
   input  logic [W-1:0] cnt_next,
   input  logic [W-1:0] count_q,
   input  logic         rearm,
   input  logic         active,
   input  logic         word_stb,
   input  logic         byte_stb,
   output logic         armed_q,
   output logic         eot_evt
);
   logic [W-1:0] done_q;
   logic [W:0]   sum;
   logic [1:0]   inc;
   logic         step;

   assign inc  = word_stb ? 2'd2 : (byte_stb ? 2'd1 : 2'd0);
   assign sum  = {1'b0, done_q} + {{(W-1){1'b0}}, inc};
   assign step = armed_q && active && (word_stb || byte_stb) && !cnt_load && !rearm;
   assign eot_evt = step && (sum >= {1'b0, count_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= '0;
         armed_q <= 1'b0;
      end else if (cnt_load) begin
         done_q  <= '0;
         armed_q <= (cnt_next != '0);
      end else if (rearm) begin
         done_q  <= '0;
         armed_q <= (count_q != '0);
      end else if (step) begin
         if (eot_evt) begin
            done_q  <= count_q;
            armed_q <= 1'b0;
         end else begin
            done_q  <= sum[W-1:0];
         end
      end
   end
endmodule

// File: rtl/xbc_dreq.sv
module xbc_dreq (
   input  logic clk,
   input  logic rst_n,
   input  logic dma_enable,
   input  logic cnt_en,
   input  logic armed_q,
   input  logic ext_eot,
   output logic rearm,
   output logic ext_evt,
   output logic dma_req
);
   logic en_prev;
   logic xoff_q;

   assign rearm   = dma_enable && !en_prev;
   assign ext_evt = ext_eot && dma_enable && !cnt_en && !xoff_q;
   assign dma_req = dma_enable && (cnt_en ? armed_q : !xoff_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_prev <= 1'b0;
         xoff_q  <= 1'b0;
      end else begin
         en_prev <= dma_enable;
         if (ext_evt)    xoff_q <= 1'b1;
         else if (rearm) xoff_q <= 1'b0;
      end
   end
endmodule

// File: rtl/xfer_byte_counter.sv
module xfer_byte_counter
   import xbc_pkg::*;
#(
   parameter int W           = 16,
   parameter int ATL_LIMIT   = 'h1000,
   parameter int ITL_LIMIT   = 'h0800,
   parameter bit EXT_EOT_IRQ = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cmd_wr,
   input  logic [7:0]   cmd_in,
   input  logic         data_wr,
   input  logic [W-1:0] data_in,
   output logic [W-1:0] data_out,
   input  logic         pio_active,
   input  logic         dma_enable,
   input  logic         word_stb,
   input  logic         byte_stb,
   input  logic         ext_eot,
   output logic         dma_req,
   output logic         irq_eot,
   output logic         buf_status_upd,
   output logic         limit_err,
   output logic         buf_sel_atl,
   output logic         buf_dir_wr
);
   if (W < 8) begin : g_bad_w
      $error("W must be at least 8");
   end
   if (ATL_LIMIT >= (1 << W) || ITL_LIMIT >= (1 << W)) begin : g_bad_lim
      $error("limits must fit in W bits");
   end
   if (ITL_LIMIT > ATL_LIMIT || ITL_LIMIT < 1) begin : g_bad_order
      $error("ITL_LIMIT must be in 1..ATL_LIMIT");
   end

   cfg_t         cfg_q;
   logic [W-1:0] count_q, cnt_next;
   logic         cnt_load, irq_clr, armed_q, eot_evt;
   logic         rearm, ext_evt, active, eot_any, irq_q, upd_q;

   xbc_regs #(.W(W), .ATL_LIMIT(ATL_LIMIT), .ITL_LIMIT(ITL_LIMIT)) u_regs (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_in(cmd_in),
      .data_wr(data_wr), .data_in(data_in), .irq_q(irq_q),
      .cfg_q(cfg_q), .count_q(count_q), .cnt_next(cnt_next),
      .cnt_load(cnt_load), .irq_clr(irq_clr), .limit_err(limit_err),
      .data_out(data_out)
   );

   assign active = pio_active || (dma_enable && cfg_q.cnt_en);

   xbc_progress #(.W(W)) u_prog (
      .clk(clk), .rst_n(rst_n), .cnt_load(cnt_load), .cnt_next(cnt_next),
      .count_q(count_q), .rearm(rearm), .active(active),
      .word_stb(word_stb), .byte_stb(byte_stb),
      .armed_q(armed_q), .eot_evt(eot_evt)
   );

   xbc_dreq u_dreq (
      .clk(clk), .rst_n(rst_n), .dma_enable(dma_enable),
      .cnt_en(cfg_q.cnt_en), .armed_q(armed_q), .ext_eot(ext_eot),
      .rearm(rearm), .ext_evt(ext_evt), .dma_req(dma_req)
   );

   if (EXT_EOT_IRQ) begin : g_ext_irq
      assign eot_any = eot_evt || ext_evt;
   end else begin : g_int_only
      assign eot_any = eot_evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         upd_q <= 1'b0;
      end else begin
         upd_q <= eot_any;
         if (eot_any)      irq_q <= 1'b1;
         else if (irq_clr) irq_q <= 1'b0;
      end
   end

   assign irq_eot        = irq_q;
   assign buf_status_upd = upd_q;
   assign buf_sel_atl    = cfg_q.sel_atl;
   assign buf_dir_wr     = cfg_q.dir_wr;
endmodule

// File: rtl/xbc_checker.sv
module xbc_checker #(
   parameter int W         = 16,
   parameter int ATL_LIMIT = 'h1000
) (
   input logic         clk,
   input logic         rst_n,
   input logic [2:0]   cfg,
   input logic [W-1:0] count_q,
   input logic         dma_enable,
   input logic         dma_req,
   input logic         irq_eot,
   input logic         irq_clr,
   input logic         buf_status_upd,
   input logic         limit_err
);
   localparam logic [W-1:0] ATL_L = ATL_LIMIT[W-1:0];

   assert_count_in_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= ATL_L);

   assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      limit_err |=> limit_err);

   assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      buf_status_upd |=> !buf_status_upd);

   assert_irq_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_eot && !irq_clr |=> irq_eot);

   assert_dreq_needs_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req && cfg[2] |-> count_q != '0);

   assert_dreq_drops_at_eot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      buf_status_upd && cfg[2] && $stable(dma_enable) |-> !dma_req);

   assert_pulse_sets_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
      buf_status_upd |-> irq_eot);
endmodule

bind xfer_byte_counter xbc_checker #(.W(W), .ATL_LIMIT(ATL_LIMIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .count_q(count_q),
   .dma_enable(dma_enable), .dma_req(dma_req), .irq_eot(irq_eot),
   .irq_clr(irq_clr), .buf_status_upd(buf_status_upd), .limit_err(limit_err)
);

// File: tb/tb_xfer_byte_counter.sv
`timescale 1ns/1ps
module tb_xfer_byte_counter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr = 0, data_wr = 0, pio_active = 0, dma_enable = 0;
   logic        word_stb = 0, byte_stb = 0, ext_eot = 0, data_rd = 0;
   logic [7:0]  cmd_in = '0;
   logic [15:0] data_in = '0;
   logic [15:0] data_out;
   logic        dma_req, irq_eot, buf_status_upd, limit_err, buf_sel_atl, buf_dir_wr;

   int compared = 0;
   int mismatched = 0;
   string       tag_q[$];
   logic [15:0] val_q[$];

   always #5 clk = ~clk;

   xfer_byte_counter dut (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_in(cmd_in),
      .data_wr(data_wr), .data_in(data_in), .data_out(data_out),
      .pio_active(pio_active), .dma_enable(dma_enable),
      .word_stb(word_stb), .byte_stb(byte_stb), .ext_eot(ext_eot),
      .dma_req(dma_req), .irq_eot(irq_eot), .buf_status_upd(buf_status_upd),
      .limit_err(limit_err), .buf_sel_atl(buf_sel_atl), .buf_dir_wr(buf_dir_wr)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read data while a data read is in progress
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (data_rd) begin
            if (tag_q.size() == 0) begin
               compared++; mismatched++;
               $display("FAIL scoreboard empty actual=%h expected=none", data_out);
            end else begin
               chk(tag_q.pop_front(), data_out, val_q.pop_front());
            end
         end
      end
   end

   task automatic tick(); @(negedge clk); endtask

   task automatic wr(input logic [7:0] c, input logic [15:0] d);
      cmd_wr = 1; cmd_in = c; tick();
      cmd_wr = 0; data_wr = 1; data_in = d; tick();
      data_wr = 0;
   endtask

   task automatic rd(input logic [7:0] c, input string tag, input logic [15:0] exp);
      cmd_wr = 1; cmd_in = c; tick();
      cmd_wr = 0; tag_q.push_back(tag); val_q.push_back(exp);
      data_rd = 1; tick();
      data_rd = 0;
   endtask

   task automatic strobe(input bit word);
      if (word) word_stb = 1; else byte_stb = 1;
      tick();
      word_stb = 0; byte_stb = 0;
   endtask

   initial begin
      for (int i = 0; i < 100000; i++) @(posedge clk);
      compared++; mismatched++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) tick();
      rst_n = 1; tick();
      // R1 reset state
      chk("R1 dma_req", 16'(dma_req), 0);
      chk("R1 irq", 16'(irq_eot), 0);
      chk("R1 upd", 16'(buf_status_upd), 0);
      chk("R1 err", 16'(limit_err), 0);
      rd(8'h22, "R1 count", 16'h0000);
      rd(8'h21, "R1 cfg", 16'h0000);
      rd(8'h24, "R1 status", 16'h0000);
      // R10 setup register
      wr(8'hA1, 16'h0003);
      rd(8'h21, "R10 cfg", 16'h0003);
      chk("R10 sel", 16'(buf_sel_atl), 1);
      chk("R10 dir", 16'(buf_dir_wr), 1);
      wr(8'hA1, 16'h0002);
      // R2 count round trip
      wr(8'hA2, 16'h0123);
      rd(8'h22, "R2 count", 16'h0123);
      chk("R2 err", 16'(limit_err), 0);
      // R11 strobe ignored when idle, then R4 counting with odd count
      wr(8'hA2, 16'd5);
      strobe(1);
      chk("R11 idle strobe", 16'(irq_eot), 0);
      pio_active = 1;
      strobe(1); chk("R4 at 2", 16'(irq_eot), 0);
      strobe(1); chk("R4 at 4", 16'(irq_eot), 0);
      strobe(0);
      chk("R4 at 5 irq", 16'(irq_eot), 1);
      chk("R5 pulse", 16'(buf_status_upd), 1);
      tick();
      chk("R5 pulse ends", 16'(buf_status_upd), 0);
      rd(8'h24, "R6 status set", 16'h0004);
      // R6 write-one-to-clear
      wr(8'hA4, 16'h0000);
      rd(8'h24, "R6 zero kept", 16'h0004);
      wr(8'hA4, 16'h0004);
      rd(8'h24, "R6 cleared", 16'h0000);
      // R9 rewrite restarts total
      wr(8'hA2, 16'd6);
      strobe(1);
      wr(8'hA2, 16'd6);
      strobe(1); strobe(1);
      chk("R9 at 4", 16'(irq_eot), 0);
      strobe(1);
      chk("R9 at 6", 16'(irq_eot), 1);
      wr(8'hA4, 16'h0004);
      pio_active = 0;
      // R7 DMA counter enabled
      wr(8'hA1, 16'h0006);
      wr(8'hA2, 16'h0000);
      dma_enable = 1; tick(); tick();
      chk("R7 zero count", 16'(dma_req), 0);
      wr(8'hA2, 16'd4);
      chk("R7 armed", 16'(dma_req), 1);
      strobe(1);
      chk("R7 mid", 16'(dma_req), 1);
      strobe(1);
      chk("R7 drop", 16'(dma_req), 0);
      chk("R7 pulse", 16'(buf_status_upd), 1);
      tick();
      chk("R7 stays low", 16'(dma_req), 0);
      dma_enable = 0; tick();
      dma_enable = 1; tick();
      chk("R7 reenable", 16'(dma_req), 1);
      dma_enable = 0; tick();
      wr(8'hA4, 16'h0004);
      // R8 DMA counter disabled
      wr(8'hA1, 16'h0002);
      dma_enable = 1; tick();
      chk("R8 follows enable", 16'(dma_req), 1);
      strobe(1);
      chk("R8 strobe ignored", 16'(irq_eot), 0);
      ext_eot = 1; tick(); ext_eot = 0;
      chk("R8 ext drop", 16'(dma_req), 0);
      chk("R8 ext irq", 16'(irq_eot), 1);
      tick();
      chk("R8 stays low", 16'(dma_req), 0);
      dma_enable = 0; tick();
      dma_enable = 1; tick();
      chk("R8 reenable", 16'(dma_req), 1);
      dma_enable = 0; tick();
      // R3 clamp
      wr(8'hA1, 16'h0000);
      wr(8'hA2, 16'h0900);
      rd(8'h22, "R3 itl clamp", 16'h0800);
      chk("R3 err", 16'(limit_err), 1);
      wr(8'hA1, 16'h0002);
      wr(8'hA2, 16'h1001);
      rd(8'h22, "R3 atl clamp", 16'h1000);
      wr(8'hA2, 16'h1000);
      rd(8'h22, "R3 atl exact", 16'h1000);
      chk("R3 err sticky", 16'(limit_err), 1);
      tick();
      if (tag_q.size() != 0) begin
         compared++; mismatched++;
         $display("FAIL scoreboard leftover actual=%0d expected=0", tag_q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule